// File: doc/BRIEF.md
# Serial Flash Erase Command Front End

This block sits behind the serial (SPI mode 0, MSB first) port of a flash model and handles only the erase commands. It resynchronises the serial clock, select and data lines into the system clock, assembles bytes while select is low, and recognises two commands: a single-sector erase made of opcode 0x7C plus a 24-bit address, and a whole-array erase given as a fixed four-byte sequence. Nothing happens while select is low. The accepted command is launched on the rising edge of select, which marks the end of the frame.

For a sector erase, the address is turned into a sector index in one of two page-size modes. The first sector is split in two parts, each erased on its own. Once launched, the block raises `busy` for a self-timed interval and reports each sector to be wiped with a one-cycle strobe carrying its index. The memory array that acts on these strobes lies outside the block. A whole-array erase walks every sector index in ascending order and leaves out those marked protected. The page-size mode and the protection mask are captured at launch.

Top module: `flash_erase_front`

## Requirements
- R1: After reset `busy` and `erase_stb` are low.
- R2: Bytes are taken MSB first on rising SCK while `spi_cs_n` is low. A frame of opcode 0x7C and three address bytes, closed by a select rise, gives exactly one strobe, in the first busy cycle. `busy` then stays high for exactly SE_CYC cycles.
- R3: Sector indices are encoded as 0 = first half of sector 0, 1 = second half of sector 0, and k+1 = sector k for k = 1..63. With `page_mode` = 0 (528-byte pages), a nonzero addr[22:17] selects index addr[22:17]+1. Bit 23 and bits 16:0 have no effect.
- R4: With `page_mode` = 0 and addr[22:17] zero, index 0 is chosen when addr[22:13] is zero, otherwise index 1. Bits 12:0 and bit 23 have no effect.
- R5: With `page_mode` = 1 (512-byte pages), sectors come from addr[21:16] and the sector 0 split from addr[21:12]. Bits 23:22 have no effect.
- R6: The bytes 0xC7, 0x94, 0x80, 0x9A, closed by a select rise, start a whole-array erase. `busy` is high for CE_CYC cycles (CE_CYC must be at least NSECT+2), and strobes come in ascending index order. Bytes after the fourth are ignored.
- R7: An unknown opcode, a wrong byte anywhere in the chip-erase sequence, or a select rise before all bytes have arrived starts nothing.
- R8: No erase starts while select stays low, even once a full command has been received.
- R9: `prot_mask` bit 0 covers indices 0 and 1, and bit k covers index k+1. A protected index gets no strobe from either command, but `busy` still runs its full time.
- R10: Every byte and select edge that arrives while `busy` is high is ignored.
- R11: `prot_mask` and `page_mode` are sampled at launch. Changing them while busy has no effect on the running erase.
- R12: A select rise with an incomplete byte pending (bit count not a multiple of 8) discards the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, asynchronous |
| spi_cs_n | input | 1 | Active-low select, asynchronous |
| spi_mosi | input | 1 | Serial data in |
| page_mode | input | 1 | 0 = 528-byte page addressing, 1 = 512-byte |
| prot_mask | input | NSECT | Per-sector protection, 1 = protected |
| busy | output | 1 | Erase in progress |
| erase_stb | output | 1 | One-cycle strobe: wipe sector erase_sector |
| erase_sector | output | SIDX_W | Sector index of the strobe (encoding in R3) |

## Verification
Sector erases are issued with addresses that put ones in the don't-care bits. Some addresses decode differently in the two page-size modes (0x4A0000 gives 38 in one mode and 11 in the other, and 0x001000 gives 0 or 1), which confirms that the field position follows `page_mode`. Whole-array erases run with an empty mask and with a mask that covers sector 0, so the skip logic and the rule that one bit guards both halves are both exercised. Negative frames cover one altered sequence byte, a truncated sequence, an unknown opcode, a short address and a trailing partial byte. Each of these must produce no busy period at all, which separates "discard" from "erase something wrong". A second frame sent during a busy period, and a mask change after launch, separate sampling at launch from sampling live inputs.

// File: rtl/fe_pkg.sv
package fe_pkg;
    localparam logic [7:0] OP_SECTOR = 8'h7C;
    localparam logic [7:0] CE_B0     = 8'hC7;
    localparam logic [7:0] CE_B1     = 8'h94;
    localparam logic [7:0] CE_B2     = 8'h80;
    localparam logic [7:0] CE_B3     = 8'h9A;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_SE_ADDR,
        PS_SE_RDY,
        PS_CE_SEQ,
        PS_CE_RDY,
        PS_DROP
    } parse_st_t;

    // expected chip-erase byte at sequence position pos (1..3)
    function automatic logic [7:0] ce_byte(input logic [1:0] pos);
        case (pos)
            2'd1:    return CE_B1;
            2'd2:    return CE_B2;
            2'd3:    return CE_B3;
            default: return CE_B0;
        endcase
    endfunction
endpackage

// File: rtl/fe_spi_rx.sv
module fe_spi_rx #(
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sck,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    output logic       byte_vld,
    output logic [7:0] rx_byte,
    output logic       cs_rise,
    output logic       cs_fall,
    output logic       bit_pend
);
    typedef struct packed {
        logic [SYNC_N-1:0] sck_sy;
        logic [SYNC_N-1:0] cs_sy;
        logic [SYNC_N-1:0] mosi_sy;
        logic              sck_p;
        logic              cs_p;
        logic [7:0]        sh;
        logic [2:0]        bcnt;
        logic              vld;
        logic [7:0]        data;
    } rx_t;

    rx_t q, d;

    logic sck_s, cs_s, mosi_s;
    assign sck_s  = q.sck_sy[SYNC_N-1];
    assign cs_s   = q.cs_sy[SYNC_N-1];
    assign mosi_s = q.mosi_sy[SYNC_N-1];

    always_comb begin
        d         = q;
        d.sck_sy  = {q.sck_sy[SYNC_N-2:0], spi_sck};
        d.cs_sy   = {q.cs_sy[SYNC_N-2:0], spi_cs_n};
        d.mosi_sy = {q.mosi_sy[SYNC_N-2:0], spi_mosi};
        d.sck_p   = sck_s;
        d.cs_p    = cs_s;
        d.vld     = 1'b0;
        if (cs_s) begin
            d.bcnt = '0;
        end else if (sck_s && !q.sck_p) begin
            d.sh   = {q.sh[6:0], mosi_s};
            d.bcnt = q.bcnt + 3'd1;
            if (q.bcnt == 3'd7) begin
                d.vld  = 1'b1;
                d.data = {q.sh[6:0], mosi_s};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.cs_sy <= '1;
            q.cs_p  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign byte_vld = q.vld;
    assign rx_byte  = q.data;
    assign cs_rise  = cs_s && !q.cs_p;
    assign cs_fall  = !cs_s && q.cs_p;
    assign bit_pend = (q.bcnt != 3'd0);
endmodule

// File: rtl/fe_cmd_parse.sv
module fe_cmd_parse
    import fe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_vld,
    input  logic [7:0]  rx_byte,
    input  logic        cs_rise,
    input  logic        cs_fall,
    input  logic        bit_pend,
    input  logic        busy,
    output logic        start_se,
    output logic        start_ce,
    output logic [23:0] addr
);
    typedef struct packed {
        parse_st_t   st;
        logic [1:0]  cnt;
        logic [23:0] addr;
    } ps_t;

    ps_t q, d;

    assign start_se = cs_rise && (q.st == PS_SE_RDY) && !bit_pend && !busy;
    assign start_ce = cs_rise && (q.st == PS_CE_RDY) && !bit_pend && !busy;
    assign addr     = q.addr;

    always_comb begin
        d = q;
        if (cs_rise || cs_fall) begin
            d.st  = PS_IDLE;
            d.cnt = '0;
        end else if (byte_vld) begin
            if (busy) begin
                d.st = PS_DROP;
            end else begin
                case (q.st)
                    PS_IDLE: begin
                        d.cnt = '0;
                        if (rx_byte == OP_SECTOR)  d.st = PS_SE_ADDR;
                        else if (rx_byte == CE_B0) begin
                            d.st  = PS_CE_SEQ;
                            d.cnt = 2'd1;
                        end else                   d.st = PS_DROP;
                    end
                    PS_SE_ADDR: begin
                        d.addr = {q.addr[15:0], rx_byte};
                        d.cnt  = q.cnt + 2'd1;
                        if (q.cnt == 2'd2) d.st = PS_SE_RDY;
                    end
                    PS_CE_SEQ: begin
                        if (rx_byte != ce_byte(q.cnt))  d.st = PS_DROP;
                        else if (q.cnt == 2'd3)         d.st = PS_CE_RDY;
                        else                            d.cnt = q.cnt + 2'd1;
                    end
                    default: d = q;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= PS_IDLE;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/fe_sector_map.sv
module fe_sector_map #(
    parameter int NSECT  = 64,
    parameter int SIDX_W = $clog2(NSECT + 1)
) (
    input  logic [23:0]       addr,
    input  logic              page_mode,
    output logic [SIDX_W-1:0] sidx
);
    localparam int SB      = $clog2(NSECT);
    localparam int PF_W    = 10;
    localparam int TOP_STD = 22;
    localparam int TOP_BIN = 21;

    logic [SB-1:0]   sec;
    logic [PF_W-1:0] pf;

    always_comb begin
        if (page_mode) begin
            sec = addr[TOP_BIN -: SB];
            pf  = addr[TOP_BIN -: PF_W];
        end else begin
            sec = addr[TOP_STD -: SB];
            pf  = addr[TOP_STD -: PF_W];
        end
        if (sec != '0)      sidx = SIDX_W'(sec) + SIDX_W'(1);
        else if (pf != '0)  sidx = SIDX_W'(1);
        else                sidx = '0;
    end
endmodule

// File: rtl/fe_erase_exec.sv
module fe_erase_exec #(
    parameter int NSECT  = 64,
    parameter int SIDX_W = $clog2(NSECT + 1),
    parameter int SE_CYC = 400,
    parameter int CE_CYC = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_se,
    input  logic              start_ce,
    input  logic [SIDX_W-1:0] se_idx,
    input  logic [NSECT-1:0]  prot_mask,
    output logic              busy,
    output logic              erase_stb,
    output logic [SIDX_W-1:0] erase_sector
);
    localparam int MAXC = (SE_CYC > CE_CYC) ? SE_CYC : CE_CYC;
    localparam int TW   = $clog2(MAXC + 1);
    localparam logic [SIDX_W-1:0] LAST_IDX = SIDX_W'(NSECT);

    typedef struct packed {
        logic              busy;
        logic [TW-1:0]     tmr;
        logic              walk;
        logic [SIDX_W-1:0] widx;
        logic [NSECT-1:0]  prot;
        logic              stb;
        logic [SIDX_W-1:0] sidx;
    } ex_t;

    ex_t q, d;

    function automatic logic is_prot(input logic [NSECT-1:0] m,
                                     input logic [SIDX_W-1:0] idx);
        if (idx < SIDX_W'(2)) return m[0];
        return m[idx - SIDX_W'(1)];
    endfunction

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        if (!q.busy) begin
            if (start_se) begin
                d.busy = 1'b1;
                d.tmr  = TW'(SE_CYC - 1);
                d.prot = prot_mask;
                d.stb  = !is_prot(prot_mask, se_idx);
                d.sidx = se_idx;
            end else if (start_ce) begin
                d.busy = 1'b1;
                d.tmr  = TW'(CE_CYC - 1);
                d.prot = prot_mask;
                d.walk = 1'b1;
                d.widx = '0;
            end
        end else begin
            if (q.tmr == '0) d.busy = 1'b0;
            else             d.tmr  = q.tmr - TW'(1);
            if (q.walk) begin
                d.stb  = !is_prot(q.prot, q.widx);
                d.sidx = q.widx;
                if (q.widx == LAST_IDX) d.walk = 1'b0;
                else                    d.widx = q.widx + SIDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy         = q.busy;
    assign erase_stb    = q.stb;
    assign erase_sector = q.sidx;
endmodule

// File: rtl/flash_erase_front.sv
module flash_erase_front #(
    parameter int NSECT  = 64,
    parameter int SIDX_W = $clog2(NSECT + 1),
    parameter int SE_CYC = 400,
    parameter int CE_CYC = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    input  logic              page_mode,
    input  logic [NSECT-1:0]  prot_mask,
    output logic              busy,
    output logic              erase_stb,
    output logic [SIDX_W-1:0] erase_sector
);
    logic        byte_vld, cs_rise, cs_fall, bit_pend;
    logic [7:0]  rx_byte;
    logic        start_se, start_ce;
    logic [23:0] cmd_addr;
    logic [SIDX_W-1:0] se_idx;

    fe_spi_rx #(.SYNC_N(2)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .byte_vld(byte_vld), .rx_byte(rx_byte),
        .cs_rise(cs_rise), .cs_fall(cs_fall), .bit_pend(bit_pend)
    );

    fe_cmd_parse u_parse (
        .clk(clk), .rst_n(rst_n),
        .byte_vld(byte_vld), .rx_byte(rx_byte),
        .cs_rise(cs_rise), .cs_fall(cs_fall), .bit_pend(bit_pend),
        .busy(busy),
        .start_se(start_se), .start_ce(start_ce), .addr(cmd_addr)
    );

    fe_sector_map #(.NSECT(NSECT), .SIDX_W(SIDX_W)) u_map (
        .addr(cmd_addr), .page_mode(page_mode), .sidx(se_idx)
    );

    fe_erase_exec #(
        .NSECT(NSECT), .SIDX_W(SIDX_W), .SE_CYC(SE_CYC), .CE_CYC(CE_CYC)
    ) u_exec (
        .clk(clk), .rst_n(rst_n),
        .start_se(start_se), .start_ce(start_ce),
        .se_idx(se_idx), .prot_mask(prot_mask),
        .busy(busy), .erase_stb(erase_stb), .erase_sector(erase_sector)
    );
endmodule

// File: rtl/fe_checker.sv
module fe_checker #(
    parameter int NSECT  = 64,
    parameter int SIDX_W = $clog2(NSECT + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              erase_stb,
    input logic [SIDX_W-1:0] erase_sector,
    input logic              cs_rise
);
    p_stb_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        erase_stb |-> busy);

    p_start_after_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise));

    p_sector_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        erase_stb |-> (erase_sector <= SIDX_W'(NSECT)));

    p_busy_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

    p_ascending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_stb && $past(erase_stb)) |-> (erase_sector > $past(erase_sector)));
endmodule

bind flash_erase_front fe_checker #(.NSECT(NSECT), .SIDX_W(SIDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .erase_stb(erase_stb),
    .erase_sector(erase_sector), .cs_rise(cs_rise)
);

// File: tb/sim_flash_erase_front.sv
`timescale 1ns/1ps
module sim_flash_erase_front;
    localparam int NSECT  = 64;
    localparam int SIDX_W = 7;
    localparam int SE_CYC = 40;
    localparam int CE_CYC = 600;
    localparam int HALF   = 4;

    typedef logic [7:0] bq_t[$];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, page_mode = 1'b0;
    logic [NSECT-1:0] prot = '0;
    logic busy, stb;
    logic [SIDX_W-1:0] sect;

    always #2.5 clk = ~clk;

    flash_erase_front #(.NSECT(NSECT), .SIDX_W(SIDX_W), .SE_CYC(SE_CYC), .CE_CYC(CE_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .page_mode(page_mode), .prot_mask(prot),
        .busy(busy), .erase_stb(stb), .erase_sector(sect)
    );

    int checks = 0, errors = 0;
    int expq[$];
    string cur_req = "R1";
    int rises = 0, falls = 0, last_len = 0, run_len = 0;
    logic busy_prev = 1'b0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: strobes against scoreboard, busy run lengths
    always @(negedge clk) begin
        if (rst_n) begin
            if (stb) begin
                if (expq.size() == 0) check(1'b0, cur_req, "unexpected strobe", sect, -1);
                else begin
                    int e;
                    e = expq.pop_front();
                    check(sect == SIDX_W'(e), cur_req, "strobe sector", sect, e);
                end
            end
            if (busy) run_len++;
            if (busy && !busy_prev) rises++;
            if (!busy && busy_prev) begin
                last_len = run_len;
                falls++;
                run_len = 0;
            end
            busy_prev = busy;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send(input bq_t bs, input int extra_bits);
        cs_n = 1'b0;
        tick(HALF);
        foreach (bs[i]) begin
            for (int b = 7; b >= 0; b--) begin
                mosi = bs[i][b];
                tick(HALF); sck = 1'b1;
                tick(HALF); sck = 1'b0;
            end
        end
        for (int b = 0; b < extra_bits; b++) begin
            mosi = 1'b1;
            tick(HALF); sck = 1'b1;
            tick(HALF); sck = 1'b0;
        end
        tick(HALF);
        cs_n = 1'b1;
        tick(HALF);
    endtask

    function automatic bit bench_prot(input int idx);
        return (idx < 2) ? prot[0] : prot[idx-1];
    endfunction

    task automatic wait_done(input int f0, input int len, input string req);
        for (int i = 0; i < 5000; i++) begin
            if (falls != f0) break;
            @(negedge clk);
        end
        check(falls == f0 + 1, req, "busy periods", falls - f0, 1);
        check(last_len == len, req, "busy length", last_len, len);
        repeat (4) @(negedge clk);
        check(expq.size() == 0, req, "strobes left", expq.size(), 0);
    endtask

    task automatic do_se(input string req, input logic [23:0] a, input int exp_idx);
        int f0;
        cur_req = req;
        if (!bench_prot(exp_idx)) expq.push_back(exp_idx);
        f0 = falls;
        send({8'h7C, a[23:16], a[15:8], a[7:0]}, 0);
        wait_done(f0, SE_CYC, req);
    endtask

    task automatic push_all();
        for (int i = 0; i <= NSECT; i++)
            if (!bench_prot(i)) expq.push_back(i);
    endtask

    task automatic expect_none(input string req, input bq_t bs, input int extra);
        int r0;
        cur_req = req;
        r0 = rises;
        send(bs, extra);
        repeat (60) @(negedge clk);
        check(rises == r0 && busy == 1'b0, req, "erase started", rises - r0, 0);
    endtask

    initial begin
        repeat (5000 * 30) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int f0;
        tick(5);
        @(negedge clk);
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(stb == 1'b0, "R1", "strobe after reset", stb, 0);
        rst_n = 1'b1;
        tick(5);

        // R2/R3: sector 5 in 528 mode, junk in don't-care bits
        page_mode = 1'b0;
        do_se("R3", 24'h8A1ABC, 6);
        do_se("R3", 24'h4A0000, 38);
        // R4: sector 0 split in 528 mode
        do_se("R4", 24'h801FFF, 0);
        do_se("R4", 24'h002000, 1);
        do_se("R4", 24'h001000, 0);
        // R5: 512 mode
        page_mode = 1'b1;
        do_se("R5", 24'h001000, 1);
        do_se("R5", 24'hFFFFFF, 64);
        do_se("R5", 24'h4A0000, 11);
        do_se("R5", 24'hC00FFF, 0);
        page_mode = 1'b0;

        // R8: full command held with select low
        cur_req = "R8";
        cs_n = 1'b0;
        tick(HALF);
        begin
            bq_t bs;
            bs = {8'h7C, 8'h0A, 8'h00, 8'h00};
            foreach (bs[i])
                for (int b = 7; b >= 0; b--) begin
                    mosi = bs[i][b];
                    tick(HALF); sck = 1'b1;
                    tick(HALF); sck = 1'b0;
                end
        end
        tick(60);
        @(negedge clk);
        check(busy == 1'b0, "R8", "busy before select rise", busy, 0);
        expq.push_back(6);
        f0 = falls;
        cs_n = 1'b1;
        tick(HALF);
        wait_done(f0, SE_CYC, "R8");

        // R9: protected sector erase gives busy but no strobe
        prot = '0; prot[5] = 1'b1;
        do_se("R9", 24'h0A0000, 6);
        prot = '0; prot[0] = 1'b1;
        do_se("R9", 24'h002000, 1);

        // R6 + R9: chip erase with mask, trailing byte ignored
        prot = '0; prot[0] = 1'b1; prot[10] = 1'b1;
        cur_req = "R6";
        push_all();
        f0 = falls;
        send({8'hC7, 8'h94, 8'h80, 8'h9A, 8'hFF}, 0);
        wait_done(f0, CE_CYC, "R6");

        // R7: malformed frames
        prot = '0;
        expect_none("R7", {8'hC7, 8'h94, 8'h81, 8'h9A}, 0);
        expect_none("R7", {8'hC7, 8'h94, 8'h80}, 0);
        expect_none("R7", {8'h55, 8'h00, 8'h00, 8'h00}, 0);
        expect_none("R7", {8'h7C, 8'h0A, 8'h00}, 0);
        // R12: trailing partial byte
        expect_none("R12", {8'h7C, 8'h0A, 8'h00, 8'h00}, 3);

        // R10: command sent during busy is ignored
        cur_req = "R10";
        push_all();
        f0 = falls;
        send({8'hC7, 8'h94, 8'h80, 8'h9A}, 0);
        send({8'h7C, 8'h06, 8'h00, 8'h00}, 0);
        check(busy == 1'b1, "R10", "second frame inside busy", busy, 1);
        wait_done(f0, CE_CYC, "R10");
        f0 = rises;
        repeat (60) @(negedge clk);
        check(rises == f0, "R10", "late start", rises - f0, 0);

        // R11: mask and mode changed after launch
        cur_req = "R11";
        push_all();
        f0 = falls;
        send({8'hC7, 8'h94, 8'h80, 8'h9A}, 0);
        wait (busy == 1'b1);
        #1;
        prot = '1;
        page_mode = 1'b1;
        wait_done(f0, CE_CYC, "R11");
        prot = '0;
        page_mode = 1'b0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule